// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block is a three-tap finite impulse response filter that works on blocks of three samples. Signed 8-bit samples arrive one at a time on a single clock, each marked by a valid strobe. A front end collects every three accepted samples into one block. For each block, the filter produces the three outputs that belong to that block's three sample positions at once.

Nine two-stage multipliers compute all three output phases in parallel. The two oldest samples of the previous block are held in a history register, so the earliest outputs of each block can use them. A coefficient set is captured together with each block. Each multiply is split into two register stages. The three lane sums are then clamped to 16 bits and registered, and a single-cycle flag marks each finished block.

Top module: `par3_fir`

## Requirements
- R1: The synchronous reset `rst` drives `y_vld` and all three outputs to zero. It also clears the history and the lane position. As a result, the first outputs after reset treat every earlier sample as zero, and a partly gathered block is discarded.
- R2: Samples are accepted only on clock edges where `smp_vld` is high. Accepted samples go in order into lane 0, lane 1 and lane 2. The third one completes a block. `smp_in` has no effect while `smp_vld` is low.
- R3: Let the block's samples be x(3k), x(3k+1) and x(3k+2). Output `y0` = h0·x(3k) + h1·x(3k−1) + h2·x(3k−2), where h0, h1 and h2 are `coef0`, `coef1` and `coef2`.
- R4: Output `y1` = h0·x(3k+1) + h1·x(3k) + h2·x(3k−1). Output `y2` = h0·x(3k+2) + h1·x(3k+1) + h2·x(3k).
- R5: x(3k−1) and x(3k−2) are the last two samples of the previous block. They are kept for any number of idle cycles between blocks.
- R6: `y_vld` is high for exactly one cycle per block. Call the edge that accepts a block's third sample edge t. The flag and the three results appear after edge t+3.
- R7: Each lane sum is formed at full width. A sum above 32767 gives 32767, a sum below −32768 gives −32768, and any other sum is passed through exactly.
- R8: The coefficients are sampled on the edge that accepts a block's third sample and are used for that whole block. Coefficient changes at any other time only affect later blocks.
- R9: Samples, coefficients and outputs are all signed two's complement.
- R10: Each product equals the exact signed product of its operands. It is computed as a high-part product and a low-part product, with a register between the two parts and the final sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Marks `smp_in` as a sample to accept |
| smp_in | input | 8 | Signed input sample |
| coef0 | input | 8 | Signed coefficient h0 (current sample) |
| coef1 | input | 8 | Signed coefficient h1 (one sample back) |
| coef2 | input | 8 | Signed coefficient h2 (two samples back) |
| y0 | output | 16 | Result for lane 0 of the block |
| y1 | output | 16 | Result for lane 1 of the block |
| y2 | output | 16 | Result for lane 2 of the block |
| y_vld | output | 1 | One-cycle flag that the three results are new |

## Verification
Two functions can happen on the same clock edge. One is the history update for a block that has just been issued. The other is the capture of the next block's first sample, along with a coefficient change that must not reach the block already in flight. The bench provokes this case by sending samples back to back with no idle cycles, and by changing the coefficients on the cycle right after a block's third sample and in the middle of a block. Every lane result is compared with a plain serial three-tap reference run on the same accepted stream, using the coefficients that were present when each block closed. The arrival cycle of each result is checked against the fixed latency.

// File: rtl/par3_fir_pkg.sv
`timescale 1ns/1ps
package par3_fir_pkg;
  // Block size (level of parallelism) and filter length.
  localparam int LANES = 3;
  localparam int TAPS  = 3;
  // Register stages inside each multiplier.
  localparam int MUL_LAT = 2;

  // Position of the next accepted sample inside the block.
  typedef enum logic [1:0] {
    PH_L0 = 2'd0,
    PH_L1 = 2'd1,
    PH_L2 = 2'd2
  } lane_e;
endpackage

// File: rtl/par3_deser.sv
`timescale 1ns/1ps
module par3_deser
  import par3_fir_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_vld,
  input  logic [SW-1:0]       in_smp,
  output logic                issue,
  output logic [LANES*SW-1:0] blk_q,
  output logic                blk_vld
);
  lane_e       ph;
  logic [SW-1:0] lane0_q;
  logic [SW-1:0] lane1_q;

  // Third sample of a block is being accepted on this edge.
  assign issue = in_vld && (ph == PH_L2);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_L0;
      lane0_q <= '0;
      lane1_q <= '0;
      blk_q   <= '0;
      blk_vld <= 1'b0;
    end else begin
      blk_vld <= issue;
      if (in_vld) begin
        case (ph)
          PH_L0: begin
            lane0_q <= in_smp;
            ph      <= PH_L1;
          end
          PH_L1: begin
            lane1_q <= in_smp;
            ph      <= PH_L2;
          end
          default: begin
            blk_q <= {in_smp, lane1_q, lane0_q};
            ph    <= PH_L0;
          end
        endcase
      end
    end
  end

  // R2: the lane position never leaves the three legal values
  p_ph_legal_r2: assert property (@(posedge clk) disable iff (rst)
    ph inside {PH_L0, PH_L1, PH_L2});

  // R2: a block is only issued after a sample was accepted
  p_blk_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    blk_vld |-> $past(in_vld));

  // R2: at least three accepted samples separate two blocks
  p_blk_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    blk_vld |=> !blk_vld);
endmodule

// File: rtl/par3_mul2.sv
`timescale 1ns/1ps
module par3_mul2 #(
  parameter int AW = 8,
  parameter int BW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic signed [AW-1:0]  a,
  input  logic signed [BW-1:0]  b,
  output logic signed [AW+BW-1:0] p
);
  localparam int LO_W = BW / 2;
  localparam int HI_W = BW - LO_W;
  localparam int LP_W = AW + LO_W + 1;
  localparam int HP_W = AW + HI_W;
  localparam int PW   = AW + BW;

  // a times the unsigned low part of b
  function automatic logic signed [LP_W-1:0] mul_lo(input logic signed [AW-1:0] x,
                                                    input logic [LO_W-1:0] y);
    logic signed [LP_W-1:0] xe;
    logic signed [LP_W-1:0] ye;
    xe = LP_W'(x);
    ye = LP_W'($signed({1'b0, y}));
    return xe * ye;
  endfunction

  // a times the signed high part of b
  function automatic logic signed [HP_W-1:0] mul_hi(input logic signed [AW-1:0] x,
                                                    input logic signed [HI_W-1:0] y);
    logic signed [HP_W-1:0] xe;
    logic signed [HP_W-1:0] ye;
    xe = HP_W'(x);
    ye = HP_W'(y);
    return xe * ye;
  endfunction

  logic signed [LP_W-1:0] lo_q;
  logic signed [HP_W-1:0] hi_q;
  logic [1:0]             age;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
      p    <= '0;
      age  <= '0;
    end else begin
      lo_q <= mul_lo(a, b[LO_W-1:0]);
      hi_q <= mul_hi(a, $signed(b[BW-1:LO_W]));
      p    <= (PW'(hi_q) <<< LO_W) + PW'(lo_q);
      if (age != 2'd2) age <= age + 2'd1;
    end
  end

  // R10: the two-stage result equals the exact product of operands two edges back
  p_mul_exact_r10: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (p == PW'($past(a, 2)) * PW'($past(b, 2))));
endmodule

// File: rtl/par3_fir.sv
`timescale 1ns/1ps
module par3_fir
  import par3_fir_pkg::*;
#(
  parameter int SW = 8,
  parameter int CW = 8,
  parameter int OW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic signed [SW-1:0] smp_in,
  input  logic signed [CW-1:0] coef0,
  input  logic signed [CW-1:0] coef1,
  input  logic signed [CW-1:0] coef2,
  output logic signed [OW-1:0] y0,
  output logic signed [OW-1:0] y1,
  output logic signed [OW-1:0] y2,
  output logic                 y_vld
);
  localparam int PW  = SW + CW;
  localparam int AW  = PW + $clog2(TAPS) + 1;
  localparam int WIN = LANES + TAPS - 1;
  localparam int HN  = TAPS - 1;
  localparam logic signed [AW-1:0] Y_MAX = AW'((1 <<< (OW - 1)) - 1);
  localparam logic signed [AW-1:0] Y_MIN = -Y_MAX - AW'(1);

  // Clamp a full-width lane sum into the output range.
  function automatic logic signed [OW-1:0] clip(input logic signed [AW-1:0] v);
    if (v > Y_MAX)      return OW'(Y_MAX);
    else if (v < Y_MIN) return OW'(Y_MIN);
    else                return OW'(v);
  endfunction

  // Serial-to-parallel front end.
  logic                issue;
  logic [LANES*SW-1:0] blk_q;
  logic                blk_vld;

  par3_deser #(.SW(SW)) u_deser (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (smp_vld),
    .in_smp  (smp_in),
    .issue   (issue),
    .blk_q   (blk_q),
    .blk_vld (blk_vld)
  );

  // Coefficient set captured with each block.
  logic signed [CW-1:0] coef_in [TAPS];
  logic signed [CW-1:0] coef_q  [TAPS];
  assign coef_in[0] = coef0;
  assign coef_in[1] = coef1;
  assign coef_in[2] = coef2;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) coef_q[i] <= '0;
    end else if (issue) begin
      for (int i = 0; i < TAPS; i++) coef_q[i] <= coef_in[i];
    end
  end

  // Sample window: oldest history first, then the block lanes.
  logic signed [SW-1:0] hist [HN];
  logic signed [SW-1:0] win  [WIN];

  always_comb begin
    for (int k = 0; k < HN; k++)    win[k]      = hist[k];
    for (int j = 0; j < LANES; j++) win[HN + j] = $signed(blk_q[j*SW +: SW]);
  end

  // Block-delay register: keeps the last samples of the issued block.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < HN; k++) hist[k] <= '0;
    end else if (blk_vld) begin
      for (int k = 0; k < HN; k++) hist[k] <= win[k + LANES];
    end
  end

  // Duplicated multiply hardware: lane j, tap i uses sample 3k+j-i.
  logic signed [PW-1:0] prd [LANES][TAPS];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
      par3_mul2 #(.AW(SW), .BW(CW)) u_mul (
        .clk (clk),
        .rst (rst),
        .a   (win[j + HN - i]),
        .b   (coef_q[i]),
        .p   (prd[j][i])
      );
    end
  end

  // Full-width lane sums.
  logic signed [AW-1:0] lane_sum [LANES];
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      lane_sum[j] = '0;
      for (int i = 0; i < TAPS; i++) lane_sum[j] = lane_sum[j] + AW'(prd[j][i]);
    end
  end

  // Valid tracking through the multiplier stages, then the output register.
  logic [MUL_LAT-1:0]    vp;
  logic signed [OW-1:0]  y_q [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      vp    <= '0;
      y_vld <= 1'b0;
      for (int j = 0; j < LANES; j++) y_q[j] <= '0;
    end else begin
      vp    <= {vp[MUL_LAT-2:0], blk_vld};
      y_vld <= vp[MUL_LAT-1];
      if (vp[MUL_LAT-1]) begin
        for (int j = 0; j < LANES; j++) y_q[j] <= clip(lane_sum[j]);
      end
    end
  end

  assign y0 = y_q[0];
  assign y1 = y_q[1];
  assign y2 = y_q[2];

  // R6: results appear a fixed three edges after the block leaves the front end
  p_vld_latency_r6: assert property (@(posedge clk) disable iff (rst)
    y_vld |-> $past(blk_vld, 3));

  // R6: one result flag per block
  p_vld_single_r6: assert property (@(posedge clk) disable iff (rst)
    y_vld |=> !y_vld);

  // R1: the flag and results are quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!y_vld && y0 == '0 && y1 == '0 && y2 == '0));
endmodule

// File: tb/test_par3_fir.sv
`timescale 1ns/1ps
module test_par3_fir;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst;
  logic              smp_vld;
  logic signed [7:0] smp_in;
  logic signed [7:0] c0, c1, c2;
  logic signed [15:0] y0, y1, y2;
  logic              y_vld;

  par3_fir i_par3_fir (
    .clk     (clk),
    .rst     (rst),
    .smp_vld (smp_vld),
    .smp_in  (smp_in),
    .coef0   (c0),
    .coef1   (c1),
    .coef2   (c2),
    .y0      (y0),
    .y1      (y1),
    .y2      (y2),
    .y_vld   (y_vld)
  );

  typedef struct {
    int    e0;
    int    e1;
    int    e2;
    int    at;
    string tag;
  } exp_t;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  int    mph = 0;
  bit    done = 1'b0;
  string cur_tag = "R3";
  int    xs[$];
  exp_t  sb[$];
  exp_t  got;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int xv(input int n);
    if (n < 0) return 0;
    return xs[n];
  endfunction

  // Serial reference: y(n) = h0 x(n) + h1 x(n-1) + h2 x(n-2), clamped to 16 bits.
  function automatic int ref_y(input int n, input int h0, input int h1, input int h2);
    int acc;
    acc = h0 * xv(n) + h1 * xv(n - 1) + h2 * xv(n - 2);
    if (acc > 32767)  return 32767;
    if (acc < -32768) return -32768;
    return acc;
  endfunction

  // Driver: called at a negedge, returns at the following negedge.
  task automatic send(input int x);
    exp_t e;
    int   n;
    smp_vld = 1'b1;
    smp_in  = 8'(x);
    @(posedge clk);
    #1;
    xs.push_back(x);
    mph++;
    if (mph == 3) begin
      mph   = 0;
      n     = xs.size() - 1;
      e.e0  = ref_y(n - 2, int'(c0), int'(c1), int'(c2));
      e.e1  = ref_y(n - 1, int'(c0), int'(c1), int'(c2));
      e.e2  = ref_y(n,     int'(c0), int'(c1), int'(c2));
      e.at  = cyc + 3;
      e.tag = cur_tag;
      sb.push_back(e);
    end
    @(negedge clk);
    smp_vld = 1'b0;
    smp_in  = 8'($urandom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      smp_in = 8'($urandom);
      @(negedge clk);
    end
  endtask

  function automatic int rnd8();
    return int'($urandom_range(0, 255)) - 128;
  endfunction

  // Monitor: compares each block of results against the scoreboard.
  always @(negedge clk) begin
    if (!rst && y_vld) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R6 result flag with no block pending", 1, 0);
      end else begin
        got = sb.pop_front();
        chk(cyc == got.at, {"R6 latency [", got.tag, "]"}, cyc, got.at);
        chk(int'(y0) == got.e0, {"R3 lane0 [", got.tag, "]"}, int'(y0), got.e0);
        chk(int'(y1) == got.e1, {"R4 lane1 [", got.tag, "]"}, int'(y1), got.e1);
        chk(int'(y2) == got.e2, {"R4 lane2 [", got.tag, "]"}, int'(y2), got.e2);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; smp_vld = 1'b0; smp_in = '0;
    c0 = '0; c1 = '0; c2 = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(y_vld == 1'b0, "R1 reset flag", int'(y_vld), 0);
    chk(y0 == 0 && y1 == 0 && y2 == 0, "R1 reset outputs", int'(y0) | int'(y1) | int'(y2), 0);
    rst = 1'b0;
    @(negedge clk);

    // R3 R4 with R1: back-to-back ramp, first block sees zero history
    cur_tag = "R3";
    c0 = 8'sd1; c1 = 8'sd2; c2 = 8'sd3;
    for (int i = 1; i <= 9; i++) send(i);

    // R5 R2: idle gaps with garbage data inside and between blocks
    cur_tag = "R5";
    c0 = -8'sd5; c1 = 8'sd7; c2 = 8'sd11;
    for (int i = 0; i < 9; i++) begin
      send(rnd8());
      idle((i % 3 == 2) ? 12 : 4);
    end

    // R9 R10: random signed samples and coefficients, random spacing
    cur_tag = "R9";
    for (int b = 0; b < 8; b++) begin
      c0 = 8'(rnd8()); c1 = 8'(rnd8()); c2 = 8'(rnd8());
      for (int i = 0; i < 3; i++) begin
        send(rnd8());
        idle(int'($urandom_range(0, 2)));
      end
    end

    // R7: clamping at both rails
    cur_tag = "R7";
    c0 = -8'sd128; c1 = -8'sd128; c2 = -8'sd128;
    for (int i = 0; i < 6; i++) send(-128);
    for (int i = 0; i < 6; i++) send(127);
    c0 = 8'sd127; c1 = 8'sd127; c2 = 8'sd127;
    for (int i = 0; i < 3; i++) send(127);

    // R8: coefficient changes mid-block and right after a block closes
    cur_tag = "R8";
    c0 = 8'sd3; c1 = 8'sd1; c2 = 8'sd2;
    for (int b = 0; b < 4; b++) begin
      send(rnd8());
      c0 = 8'(rnd8());
      send(rnd8());
      c1 = 8'(rnd8());
      send(rnd8());
      c2 = 8'(rnd8());
      c0 = 8'(rnd8());
    end

    idle(10);
    chk(sb.size() == 0, "R6 all blocks produced", sb.size(), 0);

    // R1 R2: reset during a partly filled block clears history and position
    cur_tag = "R1";
    send(99);
    send(-77);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(y_vld == 1'b0, "R1 flag in reset", int'(y_vld), 0);
    chk(y0 == 0 && y1 == 0 && y2 == 0, "R1 outputs in reset", int'(y0) | int'(y1) | int'(y2), 0);
    rst = 1'b0;
    xs.delete();
    mph = 0;
    @(negedge clk);
    c0 = 8'sd2; c1 = 8'sd3; c2 = 8'sd4;
    send(10); send(20); send(30);
    send(-1); send(-2); send(-3);
    idle(10);
    chk(sb.size() == 0, "R6 blocks after reset produced", sb.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule